// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking short-descriptor translation tables in memory. There are two table base registers and a control register. The 3-bit split field `n` in the control register divides the virtual space between the two bases: low addresses walk from base 0 and high addresses walk from base 1.

A walk begins when a request is accepted while the walker is idle. The walker issues one 32-bit read for the first-level descriptor on a single-outstanding memory port. It then either finishes or issues one more read for a second-level descriptor. The first-level descriptor may describe a 1 MiB section, a 16 MiB supersection, or a pointer to a second-level table. The second-level descriptor may describe a 64 KiB large page or a 4 KiB small page. The result comes back as a one-cycle done pulse carrying either a physical address or a fault flag.

Software programs the three configuration registers through a small write port, and only while no walk is in progress.

Top module: `ttw_walker`

## Requirements
- R1: Let `limit = 0xFFFFFFFF >> n`. A virtual address `va <= limit` walks from base 0, and any larger `va` walks from base 1. With `n = 0`, every address uses base 0.
- R2: The first-level read address is `(base & bmask) | ((va & 0xFFF00000 & range) >> 18)`. For base 0, `bmask = 0xFFFFFFFF << (14 - n)` and `range = limit`. For base 1, `bmask = 0xFFFFFFFF << 14` and `range = 0xFFFFFFFF`.
- R3: A first-level descriptor whose bits [1:0] are 00 ends the walk with a fault after a single read.
- R4: A first-level descriptor with bit 18 = 0 and bit 1 = 1 is a section. The result is `{desc[31:20], va[19:0]}`.
- R5: A first-level descriptor with bit 18 = 1 and bit 1 = 1 is a supersection. The result is `{desc[31:24], va[23:0]}`. If any bit of `desc & 0x00F001E0` is set, the walk faults instead.
- R6: Any other valid first-level descriptor is a table pointer. The walker then issues a second read at `(desc & 0xFFFFFC00) | ((va & 0x000FF000) >> 10)`.
- R7: For the second-level descriptor, [1:0] = 00 is a fault. [1:0] = 01 is a large page giving `{desc[31:16], va[15:0]}`. [1:0] = 10 or 11 is a small page giving `{desc[31:12], va[11:0]}`.
- R8: `req_ready_o` is high only when the walker is idle, and `busy_o` is high from acceptance until completion. `done_o` is a single-cycle pulse. When `done_o` is high and `fault_o` is set, `pa_o` is zero.
- R9: A memory response with `mem_rsp_err_i` set ends the walk with a fault, and no further read is issued for that walk.
- R10: Configuration writes select a register with `cfg_sel_i`: 0 is base 0, 1 is base 1, 2 is control with `n` in `wdata[2:0]`, and 3 does nothing. A write made while `busy_o` is high is ignored.
- R11: After reset, the walker is idle with `req_ready_o = 1` and `busy_o`, `mem_req_o` and `done_o` all 0. The bases and `n` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Translation request |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle, request will be taken |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Read response data (descriptor) |
| mem_rsp_err_i | input | 1 | Read response error |
| done_o | output | 1 | Walk complete pulse |
| fault_o | output | 1 | Walk ended in a fault (valid with done_o) |
| pa_o | output | 32 | Physical address (valid with done_o) |

## Verification
The bench sweeps every value of `n` and probes each split at `limit` and `limit + 1`. A walker with an off-by-one in the range compare would read its descriptor through the wrong base exactly at this edge. Each first-level address is also checked with base values that carry ones below the alignment mask. A design that forgot to mask the base would emit an address with stray low bits.

Supersections are driven both with clean extension bits and with a bit set under the extension mask. A decoder that checked only bits 18 and 1 would return a bogus address where a fault is expected. Error responses are injected on both the first and second reads to catch a walker that still issues a table read after a failed one. A configuration write is also made during a walk, followed by a walk that would show a changed base.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned SPLIT_W = 3;

  localparam logic [ADDR_W-1:0] VA_L1_MASK    = 32'hFFF0_0000;
  localparam logic [ADDR_W-1:0] VA_L2_MASK    = 32'h000F_F000;
  localparam logic [ADDR_W-1:0] TBL_PTR_MASK  = 32'hFFFF_FC00;
  localparam logic [ADDR_W-1:0] SUPER_EXT_MSK = 32'h00F0_01E0;
  localparam int unsigned       L1_IDX_SHIFT  = 18;
  localparam int unsigned       L2_IDX_SHIFT  = 10;
  localparam int unsigned       BASE_ALIGN    = 14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT
  } walk_state_e;

  typedef enum logic [1:0] {
    L1_FAULT, L1_SECTION, L1_SUPER, L1_TABLE
  } l1_kind_e;

  typedef enum logic [1:0] {
    CFG_BASE0 = 2'd0, CFG_BASE1 = 2'd1, CFG_CTRL = 2'd2, CFG_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/ttw_cfg.sv
module ttw_cfg
  import ttw_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = SPLIT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [AW-1:0] va_i,
  output logic [AW-1:0] l1_addr_o,
  output logic [2*AW+NW-1:0] snap_o
);
  localparam logic [AW-1:0] ONES = {AW{1'b1}};

  logic [AW-1:0] base0_q, base1_q;
  logic [NW-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base0_q <= '0;
      base1_q <= '0;
      n_q     <= '0;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        CFG_BASE0: base0_q <= wdata_i;
        CFG_BASE1: base1_q <= wdata_i;
        CFG_CTRL:  n_q     <= wdata_i[NW-1:0];
        default:   ;
      endcase
    end
  end

  logic [AW-1:0] limit0, mask0, mask1;
  logic          use_b1;
  logic [AW-1:0] base_sel, mask_sel, range_sel;

  always_comb begin
    limit0    = ONES >> n_q;
    mask0     = ONES << (BASE_ALIGN - int'(n_q));
    mask1     = ONES << BASE_ALIGN;
    use_b1    = va_i > limit0;
    base_sel  = use_b1 ? base1_q : base0_q;
    mask_sel  = use_b1 ? mask1   : mask0;
    range_sel = use_b1 ? ONES    : limit0;
    l1_addr_o = (base_sel & mask_sel) | ((va_i & VA_L1_MASK & range_sel) >> L1_IDX_SHIFT);
  end

  assign snap_o = {base0_q, base1_q, n_q};

  logic unused_w;
  assign unused_w = ^wdata_i[AW-1:NW];
endmodule

// File: rtl/ttw_l1_decode.sv
module ttw_l1_decode
  import ttw_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output l1_kind_e      kind_o,
  output logic [AW-1:0] pa_o,
  output logic [AW-1:0] l2_addr_o
);
  always_comb begin
    pa_o      = '0;
    l2_addr_o = (desc_i & TBL_PTR_MASK) | ((va_i & VA_L2_MASK) >> L2_IDX_SHIFT);
    if (desc_i[1:0] == 2'b00) begin
      kind_o = L1_FAULT;
    end else if (desc_i[1]) begin
      if (desc_i[18]) begin
        if ((desc_i & SUPER_EXT_MSK) != '0) begin
          kind_o = L1_FAULT;
        end else begin
          kind_o = L1_SUPER;
          pa_o   = {desc_i[31:24], va_i[23:0]};
        end
      end else begin
        kind_o = L1_SECTION;
        pa_o   = {desc_i[31:20], va_i[19:0]};
      end
    end else begin
      kind_o = L1_TABLE;
    end
  end
endmodule

// File: rtl/ttw_l2_decode.sv
module ttw_l2_decode
  import ttw_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output logic          fault_o,
  output logic [AW-1:0] pa_o
);
  always_comb begin
    fault_o = 1'b0;
    unique case (desc_i[1:0])
      2'b00:   begin fault_o = 1'b1; pa_o = '0; end
      2'b01:   pa_o = {desc_i[31:16], va_i[15:0]};
      default: pa_o = {desc_i[31:12], va_i[11:0]};
    endcase
  end
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker
  import ttw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_sel_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        req_valid_i,
  input  logic [31:0] req_va_i,
  output logic        req_ready_o,
  output logic        busy_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i,
  input  logic        mem_rsp_err_i,
  output logic        done_o,
  output logic        fault_o,
  output logic [31:0] pa_o
);
  localparam int unsigned AW     = ADDR_W;
  localparam int unsigned SNAP_W = 2 * AW + SPLIT_W;

  walk_state_e   state_q, state_d;
  logic [AW-1:0] va_q, l2_addr_q;
  logic          done_q, fault_q;
  logic [AW-1:0] pa_q;
  logic          idle;

  logic [AW-1:0]     l1_addr;
  logic [SNAP_W-1:0] cfg_snap;
  l1_kind_e          l1_kind;
  logic [AW-1:0]     l1_pa, l1_next;
  logic              l2_fault;
  logic [AW-1:0]     l2_pa;

  assign idle = (state_q == ST_IDLE);

  ttw_cfg #(.AW(AW), .NW(SPLIT_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i && idle),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .va_i     (va_q),
    .l1_addr_o(l1_addr),
    .snap_o   (cfg_snap)
  );

  ttw_l1_decode #(.AW(AW)) u_l1 (
    .desc_i   (mem_rsp_data_i),
    .va_i     (va_q),
    .kind_o   (l1_kind),
    .pa_o     (l1_pa),
    .l2_addr_o(l1_next)
  );

  ttw_l2_decode #(.AW(AW)) u_l2 (
    .desc_i (mem_rsp_data_i),
    .va_i   (va_q),
    .fault_o(l2_fault),
    .pa_o   (l2_pa)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_L1_REQ;
      ST_L1_REQ:  state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid_i)
                    state_d = (!mem_rsp_err_i && l1_kind == L1_TABLE) ? ST_L2_REQ : ST_IDLE;
      ST_L2_REQ:  state_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      va_q      <= '0;
      l2_addr_q <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      pa_q      <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (idle && req_valid_i) va_q <= req_va_i;
      if (state_q == ST_L1_WAIT && mem_rsp_valid_i) begin
        if (mem_rsp_err_i || l1_kind == L1_FAULT) begin
          done_q <= 1'b1; fault_q <= 1'b1; pa_q <= '0;
        end else if (l1_kind == L1_TABLE) begin
          l2_addr_q <= l1_next;
        end else begin
          done_q <= 1'b1; fault_q <= 1'b0; pa_q <= l1_pa;
        end
      end
      if (state_q == ST_L2_WAIT && mem_rsp_valid_i) begin
        done_q  <= 1'b1;
        fault_q <= mem_rsp_err_i || l2_fault;
        pa_q    <= (mem_rsp_err_i || l2_fault) ? '0 : l2_pa;
      end
    end
  end

  assign req_ready_o = idle;
  assign busy_o      = !idle;
  assign mem_req_o   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o  = (state_q == ST_L2_REQ) ? l2_addr_q : l1_addr;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign pa_o        = pa_q;
endmodule

// File: rtl/ttw_walker_chk.sv
module ttw_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic        mem_rsp_valid_i,
  input logic        mem_rsp_err_i,
  input logic        done_o,
  input logic        fault_o,
  input logic [31:0] pa_o,
  input logic [66:0] cfg_snap
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> busy_o);  // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8

  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> pa_o == 32'h0);  // R8

  AST_MEM_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);  // R2

  AST_NO_READ_AFTER_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mem_rsp_valid_i && mem_rsp_err_i |=> !mem_req_o);  // R9

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cfg_snap));  // R10
endmodule

bind ttw_walker ttw_walker_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .busy_o         (busy_o),
  .mem_req_o      (mem_req_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .mem_rsp_err_i  (mem_rsp_err_i),
  .done_o         (done_o),
  .fault_o        (fault_o),
  .pa_o           (pa_o),
  .cfg_snap       (cfg_snap)
);

// File: tb/tb_ttw_walker.sv
module tb_ttw_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic        req_ready_o, busy_o, mem_req_o, done_o, fault_o;
  logic [31:0] mem_addr_o, pa_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        mem_rsp_err_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] b0_cur = '0, b1_cur = '0;
  int          n_cur = 0;

  always #10 clk_i = ~clk_i;

  ttw_walker dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", cycles, 150000);
      finish_run();
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] b0, input logic [31:0] b1, input int n);
    cfg_write(2'd0, b0);
    cfg_write(2'd1, b1);
    cfg_write(2'd2, 32'hFFFF_FFF8 | 32'(n));
    b0_cur = b0; b1_cur = b1; n_cur = n;
  endtask

  task automatic run_walk(input logic [31:0] va, input logic [31:0] d1, input bit e1,
                          input logic [31:0] d2, input bit e2, input bit poke,
                          input string addr_tag);
    logic [31:0] limit, bm, rng, base, l1a, l2a, pa_e;
    logic [31:0] addr [2];
    int reads_e, reads;
    bit fault_e, seen;
    string tag;
    limit = 32'hFFFF_FFFF >> n_cur;
    if (va > limit) begin
      base = b1_cur; bm = 32'hFFFF_FFFF << 14; rng = 32'hFFFF_FFFF;
    end else begin
      base = b0_cur; bm = 32'hFFFF_FFFF << (14 - n_cur); rng = limit;
    end
    l1a = (base & bm) | ((va & 32'hFFF0_0000 & rng) >> 18);
    l2a = (d1 & 32'hFFFF_FC00) | ((va & 32'h000F_F000) >> 10);
    reads_e = 1; fault_e = 1'b0; pa_e = '0;
    if (e1) begin fault_e = 1'b1; tag = "R9"; end
    else if (d1[1:0] == 2'b00) begin fault_e = 1'b1; tag = "R3"; end
    else if (d1[1] && !d1[18]) begin pa_e = {d1[31:20], va[19:0]}; tag = "R4"; end
    else if (d1[1] && d1[18]) begin
      tag = "R5";
      if ((d1 & 32'h00F0_01E0) != 0) fault_e = 1'b1;
      else pa_e = {d1[31:24], va[23:0]};
    end else begin
      reads_e = 2; tag = "R7";
      if (e2) begin fault_e = 1'b1; tag = "R9"; end
      else if (d2[1:0] == 2'b00) fault_e = 1'b1;
      else if (d2[1:0] == 2'b01) pa_e = {d2[31:16], va[15:0]};
      else pa_e = {d2[31:12], va[11:0]};
    end

    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R8 ready before request", {31'b0, req_ready_o}, 32'h1);
    req_valid_i = 1'b1; req_va_i = va;
    reads = 0; seen = 1'b0;
    for (int c = 0; c < 40 && !seen; c++) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      mem_rsp_valid_i = 1'b0; mem_rsp_err_i = 1'b0; cfg_we_i = 1'b0;
      if (done_o) begin
        seen = 1'b1;
      end else if (mem_req_o) begin
        if (reads < 2) addr[reads] = mem_addr_o;
        if (reads == 0) chk(busy_o == 1'b1, "R8 busy during walk", {31'b0, busy_o}, 32'h1);
        if (reads == 0 && poke) begin
          cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_wdata_i = 32'hDEAD_0000;
        end
        reads++;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = (reads == 1) ? d1 : d2;
        mem_rsp_err_i   = (reads == 1) ? e1 : e2;
      end
    end
    mem_rsp_valid_i = 1'b0; mem_rsp_err_i = 1'b0;
    chk(seen, "R8 done reached", {31'b0, seen}, 32'h1);
    chk(reads == reads_e, (reads_e == 1) ? "R9/R3 read count" : "R6 read count", reads, reads_e);
    if (reads >= 1)
      chk(addr[0] == l1a, (addr_tag != "") ? addr_tag : "R1 R2 first-level address", addr[0], l1a);
    if (reads >= 2 && reads_e == 2)
      chk(addr[1] == l2a, "R6 second-level address", addr[1], l2a);
    chk(fault_o == fault_e, {tag, " fault flag"}, {31'b0, fault_o}, {31'b0, fault_e});
    chk(pa_o == pa_e, {tag, " physical address"}, pa_o, pa_e);
    @(negedge clk_i);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8 done single cycle", {30'b0, done_o, busy_o}, 32'h0);
  endtask

  initial begin
    logic [31:0] vas [4];
    logic [31:0] lim;
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !busy_o && !mem_req_o && !done_o, "R11 reset outputs",
        {28'b0, req_ready_o, busy_o, mem_req_o, done_o}, 32'h8);
    rst_ni = 1'b1;
    // R11: zero bases, n=0: first-level address for va 0x00300000 is 0x0000000C
    run_walk(32'h0030_0000, 32'h0000_0000, 1'b0, 32'h0, 1'b0, 1'b0, "R11 reset config");
    // R10: select 3 writes nothing
    cfg_write(2'd3, 32'hFFFF_FFFF);
    run_walk(32'h0030_0000, 32'h0000_0000, 1'b0, 32'h0, 1'b0, 1'b0, "R10 select 3 no effect");

    for (int n = 0; n < 8; n++) begin
      set_cfg(32'h1234_5678, 32'h9ABC_DEF0, n);
      lim = 32'hFFFF_FFFF >> n;
      vas[0] = 32'h0001_2345; vas[1] = lim; vas[2] = lim + 32'd1; vas[3] = 32'hFFFF_F678;
      for (int v = 0; v < 4; v++) begin
        run_walk(vas[v], 32'hABCD_E000, 1'b0, 32'h0,        1'b0, 1'b0, "");
        run_walk(vas[v], 32'h5A30_0C02, 1'b0, 32'h0,        1'b0, 1'b0, "");
        run_walk(vas[v], 32'h7B04_0002, 1'b0, 32'h0,        1'b0, 1'b0, "");
        run_walk(vas[v], 32'h7B04_00A2, 1'b0, 32'h0,        1'b0, 1'b0, "");
        run_walk(vas[v], 32'h3C4D_5E01, 1'b0, 32'h1111_1110, 1'b0, 1'b0, "");
        run_walk(vas[v], 32'h3C4D_5E01, 1'b0, 32'h2233_4401, 1'b0, 1'b0, "");
        run_walk(vas[v], 32'h3C4D_5E01, 1'b0, 32'h4455_660E, 1'b0, 1'b0, "");
        run_walk(vas[v], 32'h3C4D_5E01, 1'b0, 32'h4455_660F, 1'b0, 1'b0, "");
        run_walk(vas[v], 32'h5A30_0C02, 1'b1, 32'h0,        1'b0, 1'b0, "");
        run_walk(vas[v], 32'h3C4D_5E01, 1'b0, 32'h4455_660E, 1'b1, 1'b0, "");
      end
    end

    // R10: base-0 write during a walk must not land
    set_cfg(32'h0000_4000, 32'h0001_0000, 0);
    run_walk(32'h0010_0000, 32'h5A30_0C02, 1'b0, 32'h0, 1'b0, 1'b1, "");
    run_walk(32'h0020_0000, 32'h5A30_0C02, 1'b0, 32'h0, 1'b0, 1'b0, "R10 write during walk ignored");

    finish_run();
  end
endmodule